// File: doc/BRIEF.md
# Scanline-Prescaled Interrupt Timer

This block is the interrupt timer of a cartridge mapper. It runs from the CPU clock, advances on a one-cycle CPU tick strobe, and counts approximate video scanlines. Each enabled CPU cycle adds three pixel clocks to a prescaler. When the prescaler reaches the line length of 341 pixel clocks, that length is removed from it and an 8-bit up-counter steps by one. When the counter passes 255, the block raises a level interrupt request and reloads the counter from an 8-bit reload value.

Software drives the block through write strobes, each with a 16-bit address and 8-bit data. Two addresses load the reload value one nibble at a time. A third address restarts the timer: it clears the prescaler, copies the reload value into the counter and sets the run enable from data bit 1. A write to any of the three addresses also clears the pending request. The write port has no back-pressure. A write is taken in the cycle its strobe is high, so no ready signal exists. The interrupt output is a plain level.

Top module: `scanline_irq_timer`

## Requirements
- R1: A write to address 0xF000 sets bits 3:0 of the reload value to data bits 3:0. A write to 0xF004 sets bits 7:4 of the reload value to data bits 3:0. Data bits 7:4 are ignored in both cases, and the other nibble keeps its value.
- R2: A write to 0xF008 clears the prescaler to 0, loads the counter with the reload value and sets the run enable to data bit 1.
- R3: A write to 0xF000, 0xF004 or 0xF008 deasserts `irq` on the next cycle. The one exception is an overflow in that same cycle, which keeps `irq` high.
- R4: While enabled, each cycle with `cpu_tick` high adds 3 to the prescaler.
- R5: When the prescaler plus 3 is 341 or more, the prescaler becomes that sum minus 341 and the counter increments by one. The prescaler never holds a value of 341 or more.
- R6: An increment from counter value 255 asserts `irq` on the next cycle. In that case the counter is loaded with the reload value instead of wrapping to 0.
- R7: While disabled, neither the prescaler nor the counter changes, whatever `cpu_tick` does.
- R8: Once asserted, `irq` stays high until one of the writes in R3 clears it.
- R9: Reset (`rst_n` low, asynchronous) clears the reload value, counter, prescaler, enable and `irq`.
- R10: A write to any other address changes no timer state and does not affect `irq`.
- R11: When a write and a tick fall in the same cycle, a 0xF008 write takes precedence and the tick is lost. Writes to 0xF000 and 0xF004 do not block the tick, and a reload in that cycle uses the reload value as it stood before the write.
- R12: With reload value 0xFE, enable set and a tick every cycle, `irq` first rises after the 228th tick following the 0xF008 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_tick | input | 1 | One CPU cycle has elapsed; advances the prescaler |
| wr_en | input | 1 | Write strobe, accepted in the cycle it is high |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `wr_addr` and `wr_data` are meaningful only while `wr_en` is high, and that `cpu_tick` may take any value in any cycle, including cycles that carry a write. The stimulus meets these assumptions. It draws ticks and writes independently each cycle from a seeded generator, so writes and ticks often coincide. Writes are spread over the three timer addresses and over nearby decoy addresses. Reload values are biased towards the top of the range, so overflows and acknowledges collide often within a short run.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  // Register selected by a write strobe
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_CTL  = 2'd3
  } wr_sel_e;

  localparam int unsigned DEF_LINE_LEN = 341;
  localparam int unsigned DEF_STEP     = 3;
endpackage

// File: rtl/scanline_irq_decode.sv
module scanline_irq_decode
  import scanline_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RELOAD_W = 8,
  parameter int unsigned EN_BIT   = 1,
  parameter logic [ADDR_W-1:0] ADDR_LO  = 16'hF000,
  parameter logic [ADDR_W-1:0] ADDR_HI  = 16'hF004,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 16'hF008
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [RELOAD_W-1:0] reload_q,
  output logic                run_q,
  output logic                restart,
  output logic                ack
);
  localparam int unsigned NIB = RELOAD_W / 2;

  wr_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (wr_en) begin
      if (wr_addr == ADDR_LO)       sel = SEL_LO;
      else if (wr_addr == ADDR_HI)  sel = SEL_HI;
      else if (wr_addr == ADDR_CTL) sel = SEL_CTL;
    end
  end

  assign restart = (sel == SEL_CTL);
  assign ack     = (sel != SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      run_q    <= 1'b0;
    end else begin
      case (sel)
        SEL_LO:  reload_q[NIB-1:0]        <= wr_data[NIB-1:0];
        SEL_HI:  reload_q[RELOAD_W-1:NIB] <= wr_data[NIB-1:0];
        SEL_CTL: run_q                    <= wr_data[EN_BIT];
        default: ;
      endcase
    end
  end

  logic unused_data;
  assign unused_data = ^wr_data[DATA_W-1:NIB];
endmodule

// File: rtl/scanline_irq_prescale.sv
module scanline_irq_prescale #(
  parameter int unsigned PRE_W    = 9,
  parameter int unsigned LINE_LEN = 341,
  parameter int unsigned STEP     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clear,
  output logic [PRE_W-1:0] pre_q,
  output logic             line_step
);
  localparam int unsigned SUM_W = PRE_W + 1;
  localparam logic [SUM_W-1:0] LEN_V  = SUM_W'(LINE_LEN);
  localparam logic [SUM_W-1:0] STEP_V = SUM_W'(STEP);

  logic             adv;
  logic [SUM_W-1:0] sum;
  logic             wrap;
  logic [SUM_W-1:0] wrapped;

  assign adv       = tick && run && !clear;
  assign sum       = {1'b0, pre_q} + STEP_V;
  assign wrap      = (sum >= LEN_V);
  assign wrapped   = sum - LEN_V;
  assign line_step = adv && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
    end else if (adv) begin
      pre_q <= wrap ? wrapped[PRE_W-1:0] : sum[PRE_W-1:0];
    end
  end
endmodule

// File: rtl/scanline_irq_count.sv
module scanline_irq_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             carry
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign carry = step && !reload && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reload || carry) begin
      cnt_q <= reload_val;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
  import scanline_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRE_W    = 9,
  parameter int unsigned LINE_LEN = DEF_LINE_LEN,
  parameter int unsigned STEP     = DEF_STEP,
  parameter logic [ADDR_W-1:0] ADDR_LO  = 16'hF000,
  parameter logic [ADDR_W-1:0] ADDR_HI  = 16'hF004,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 16'hF008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  logic [CNT_W-1:0] reload_q;
  logic             run_q;
  logic             restart;
  logic             ack;
  logic [PRE_W-1:0] pre_q;
  logic             line_step;
  logic [CNT_W-1:0] cnt_q;
  logic             carry;
  logic             irq_q;

  scanline_irq_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOAD_W(CNT_W), .EN_BIT(1),
    .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .ADDR_CTL(ADDR_CTL)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload_q(reload_q), .run_q(run_q),
    .restart(restart), .ack(ack)
  );

  scanline_irq_prescale #(
    .PRE_W(PRE_W), .LINE_LEN(LINE_LEN), .STEP(STEP)
  ) u_prescale (
    .clk(clk), .rst_n(rst_n), .tick(cpu_tick), .run(run_q),
    .clear(restart), .pre_q(pre_q), .line_step(line_step)
  );

  scanline_irq_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .step(line_step), .reload(restart),
    .reload_val(reload_q), .cnt_q(cnt_q), .carry(carry)
  );

  // Overflow wins over a simultaneous acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (carry) irq_q <= 1'b1;
    else if (ack)   irq_q <= 1'b0;
  end

  assign irq = irq_q;
endmodule

// File: rtl/scanline_irq_checker.sv
module scanline_irq_checker #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRE_W    = 9,
  parameter int unsigned LINE_LEN = 341,
  parameter int unsigned STEP     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_tick,
  input logic             ack,
  input logic             restart,
  input logic             run_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             carry,
  input logic             irq
);
  localparam logic [PRE_W-1:0] LEN_P  = PRE_W'(LINE_LEN);
  localparam logic [PRE_W-1:0] STEP_P = PRE_W'(STEP);

  // R2
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0) && (cnt_q == $past(reload_q)));

  // R3
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !carry) |=> !irq);

  // R4
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_tick && run_q && !restart && (pre_q < LEN_P - STEP_P))
      |=> (pre_q == $past(pre_q) + STEP_P) && $stable(cnt_q));

  // R5
  p_pre_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q < LEN_P);

  // R6
  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> irq && (cnt_q == $past(reload_q)));

  // R7
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !restart) |=> $stable(pre_q) && $stable(cnt_q));

  // R8
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
endmodule

bind scanline_irq_timer scanline_irq_checker #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .LINE_LEN(LINE_LEN), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .ack(ack),
  .restart(restart), .run_q(run_q), .pre_q(pre_q), .cnt_q(cnt_q),
  .reload_q(reload_q), .carry(carry), .irq(irq)
);

// File: tb/scanline_irq_timer_tb.sv
module scanline_irq_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // Reference state
  logic [7:0] m_reload;
  logic       m_run;
  int         m_pre;
  int         m_cnt;
  logic       m_irq;

  scanline_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: irq actual %0b expected %0b", req, cycles, act, exp);
    end
  endtask

  function automatic int ticks_to_fire(input logic [7:0] rv);
    int p = 0, c = rv, k = 0;
    forever begin
      k++;
      p += 3;
      if (p >= 341) begin
        p -= 341;
        if (c == 255) return k;
        c++;
      end
    end
  endfunction

  task automatic model_reset();
    m_reload = '0; m_run = 1'b0; m_pre = 0; m_cnt = 0; m_irq = 1'b0;
  endtask

  // Reference update for one clock edge, from the inputs of that cycle
  task automatic model_edge(input logic t, input logic w, input logic [15:0] a,
                            input logic [7:0] d);
    logic [7:0] old_rv = m_reload;
    logic is_lo  = w && (a == 16'hF000);
    logic is_hi  = w && (a == 16'hF004);
    logic is_ctl = w && (a == 16'hF008);
    logic fire   = 1'b0;
    if (is_ctl) begin
      m_pre = 0; m_cnt = old_rv; m_run = d[1];           // R2, R11
    end else if (t && m_run) begin
      m_pre += 3;                                          // R4
      if (m_pre >= 341) begin                              // R5
        m_pre -= 341;
        if (m_cnt == 255) begin fire = 1'b1; m_cnt = old_rv; end  // R6
        else m_cnt++;
      end
    end
    if (is_lo) m_reload[3:0] = d[3:0];                     // R1
    if (is_hi) m_reload[7:4] = d[3:0];
    if (fire) m_irq = 1'b1;
    else if (is_lo || is_hi || is_ctl) m_irq = 1'b0;       // R3, R10
  endtask

  task automatic cyc(input logic t, input logic w, input logic [15:0] a,
                     input logic [7:0] d, input string req);
    cpu_tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(t, w, a, d);
    @(negedge clk);
    check(req, irq, m_irq);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R9 reset", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: idle after reset, ticks do nothing
    for (int i = 0; i < 400; i++) cyc(1'b1, 1'b0, 16'h0, 8'h0, "R7");

    // R1: upper data bits ignored; reload = 0xFE
    cyc(1'b0, 1'b1, 16'hF000, 8'hAE, "R1");
    cyc(1'b0, 1'b1, 16'hF004, 8'h5F, "R1");
    cyc(1'b0, 1'b1, 16'hF008, 8'h02, "R2");
    // R12: exact fire time
    for (int i = 1; i <= 228; i++) begin
      cyc(1'b1, 1'b0, 16'h0, 8'h0, "R12");
      if (i == 227) check("R12 before fire", irq, 1'b0);
      if (i == 228) check("R12 fire", irq, 1'b1);
    end
    if (ticks_to_fire(8'hFE) != 228) begin
      n_checks++; n_fail++;
      $display("FAIL R12 model: actual %0d expected 228", ticks_to_fire(8'hFE));
    end
    // R8: stays high without ack; R10 decoys do not ack
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 16'h0, 8'h0, "R8");
    cyc(1'b0, 1'b1, 16'hF00C, 8'hFF, "R10");
    cyc(1'b0, 1'b1, 16'hF001, 8'hFF, "R10");
    check("R8 held", irq, 1'b1);
    // R3: ack by nibble write
    cyc(1'b0, 1'b1, 16'hF004, 8'h0F, "R3");
    check("R3 ack", irq, 1'b0);

    // R2: enable bit clear -> never fires
    cyc(1'b0, 1'b1, 16'hF000, 8'h0F, "R1");
    cyc(1'b0, 1'b1, 16'hF008, 8'hFD, "R2");
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 16'h0, 8'h0, "R7 disabled");
    check("R7 no fire", irq, 1'b0);

    // R11: restart collides with ticks; overflow vs ack in same cycle
    cyc(1'b1, 1'b1, 16'hF008, 8'h02, "R11");
    for (int i = 0; i < 113; i++) cyc(1'b1, 1'b0, 16'h0, 8'h0, "R11");
    cyc(1'b1, 1'b1, 16'hF000, 8'h00, "R11 fire beats ack");
    check("R3 fire beats ack", irq, 1'b1);

    // Constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 60000; i++) begin
      logic t = ($urandom % 4) != 0;
      logic w = ($urandom % 16) == 0;
      logic [15:0] a;
      logic [7:0] d = 8'($urandom);
      case ($urandom % 5)
        0: a = 16'hF000;
        1: a = 16'hF004;
        2: begin a = 16'hF008; if ($urandom % 4 != 0) d[1] = 1'b1; end
        3: a = 16'hF000 | 16'($urandom % 16);
        default: a = 16'($urandom);
      endcase
      if (a == 16'hF004 && ($urandom % 2)) d[3:0] = 4'hF;
      cyc(t, w, a, d, "R4 R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule